// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital sequencer of an 8-bit successive-approximation converter that a host drives over a four-wire serial link. The link has an active-low select, a serial clock, a command input and a result output. The host lowers select and clocks in a command on rising serial-clock edges. The command is a start bit, an input-mode bit and a channel address. The block then waits half a serial period for acquisition. On each of the next eight falling edges it settles one bit of the code by binary search. It presents the trial code to an external comparator and reads back the comparator decision.

Each bit leaves on the data output at the moment it is decided, most significant bit first. The block then plays the finished code out again, least significant bit first, and finally drops its busy status. Both the data output and the status output have output enables, and these are off whenever select is high. Raising select at any point abandons the sequence.

The serial pins are sampled by a fast system clock through a synchronizer of parameterised depth. All serial-clock edges are found from the synchronized copy.

Top module: `sar_seq`

## Requirements
- R1: After reset, `dout_oe` and `busy_oe` are 0, `busy_bit` is 0 and `trial_code` is 0.
- R2: `dout_oe` and `busy_oe` are equal at all times. Both are 0 within a few system clocks of `cs_n` going high and stay 0 while it remains high, whatever `sclk` and `din` do.
- R3: With select low, `din` is sampled on rising `sclk` edges, and 0 bits before the first 1 are ignored. The first 1 is the start bit. The next bit is the mode (1 = single-ended, 0 = differential). The three bits after that are the channel address, most significant first. Mode and address appear on `mux_single` and `mux_addr` once the last address bit has been taken.
- R4: On the falling `sclk` edge that follows the last address bit, `busy_bit` rises and `trial_code` becomes 8'h80.
- R5: On each of the next 8 falling edges one bit is decided, starting at bit 7. The bit is kept when `cmp_ge` is 1. After the decision, `trial_code` equals the kept bits ORed with the next lower test bit, or the final code after bit 0.
- R6: In the same 8 falling edges, `dout_bit` takes the value of the decision made on that edge.
- R7: On the following 8 falling edges, `dout_bit` presents the final code bit 0 first, up to bit 7.
- R8: On the falling edge after the last of those bits, `busy_bit` and `dout_bit` return to 0. No further conversion starts until select has been raised.
- R9: When the comparator never reports 1 (negative input at or above positive input), the code is 8'h00 on both readouts.
- R10: A rise of `cs_n` at any time ends the sequence: `busy_bit` and `trial_code` return to 0. After select falls again, a new start bit is needed.
- R11: While enabled, `dout_bit` changes only right after a falling `sclk` edge and never at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial command input |
| cmp_ge | input | 1 | Comparator decision: analog input at or above `trial_code` |
| trial_code | output | 8 | Code under test, presented to the comparator |
| mux_addr | output | 3 | Latched channel address |
| mux_single | output | 1 | Latched mode, 1 = single-ended |
| dout_bit | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout_bit` |
| busy_bit | output | 1 | Conversion in progress |
| busy_oe | output | 1 | Output enable for `busy_bit` |

## Verification
A wrong step count or a corrupt search register shows on the data pin within one serial period. It appears as a misplaced or wrong bit in the MSB-first stream, and the trial code can be compared on every falling edge. A phase error between the two readouts, or a lost final bit, shows as a mismatch of the LSB-first stream against the MSB-first one. It can also show as busy dropping one serial period early or late. An abort that leaves stale state is seen within a few system clocks, because the trial code stays non-zero after select rises. A stale state is also seen when the next session converts without a start bit.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ARM,
      ST_CONV,
      ST_DONE
   } seq_state_t;
endpackage

// File: rtl/sar_seq_sync.sv
module sar_seq_sync #(
   parameter int SYNC_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic din,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_n_s,
   output logic din_s
);
   localparam int LAST = SYNC_DEPTH - 1;

   generate
      if (SYNC_DEPTH < 1) begin : g_bad_depth
         $error("sar_seq_sync: SYNC_DEPTH must be at least 1");
      end
   endgenerate

   // bit 2 = select, bit 1 = data, bit 0 = serial clock
   logic [2:0] chain [SYNC_DEPTH];
   logic       sclk_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_DEPTH; i++) chain[i] <= 3'b100;
         sclk_prev <= 1'b0;
      end else begin
         chain[0] <= {cs_n, din, sclk};
         for (int i = 1; i < SYNC_DEPTH; i++) chain[i] <= chain[i-1];
         sclk_prev <= chain[LAST][0];
      end
   end

   assign sclk_rise = chain[LAST][0] & ~sclk_prev;
   assign sclk_fall = ~chain[LAST][0] & sclk_prev;
   assign cs_n_s    = chain[LAST][2];
   assign din_s     = chain[LAST][1];
endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             arm,
   input  logic             step,
   input  logic             cmp_ge,
   output logic [WIDTH-1:0] trial,
   output logic [WIDTH-1:0] result
);
   localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] kept;
   logic [WIDTH-1:0] probe;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         kept  <= '0;
         probe <= '0;
      end else if (arm) begin
         kept  <= '0;
         probe <= TOP_BIT;
      end else if (step && (probe != '0)) begin
         if (cmp_ge) kept <= kept | probe;
         probe <= probe >> 1;
      end
   end

   assign trial  = kept | probe;
   assign result = kept;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_seq_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int ADDR_W     = 3,
   parameter int SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              din,
   input  logic              cmp_ge,
   output logic [WIDTH-1:0]  trial_code,
   output logic [ADDR_W-1:0] mux_addr,
   output logic              mux_single,
   output logic              dout_bit,
   output logic              dout_oe,
   output logic              busy_bit,
   output logic              busy_oe
);
   localparam int CMD_W = ADDR_W + 1;
   localparam int CC_W  = (CMD_W > 1) ? $clog2(CMD_W) : 1;
   localparam int CNT_W = $clog2(2 * WIDTH + 1);
   localparam int IDX_W = $clog2(WIDTH);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_seq: WIDTH must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("sar_seq: ADDR_W must be at least 1");
      end
   endgenerate

   logic sclk_rise, sclk_fall, cs_n_s, din_s;

   sar_seq_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .din       (din),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_n_s    (cs_n_s),
      .din_s     (din_s)
   );

   seq_state_t        state;
   logic [CMD_W-1:0]  cmd_sr;
   logic [CC_W-1:0]   cmd_cnt;
   logic [CNT_W-1:0]  step_cnt;
   logic [CNT_W-1:0]  lsb_pos;
   logic              dout_q, busy_q, single_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WIDTH-1:0]  result;

   logic abort, core_flush, core_arm, core_step;
   assign abort      = cs_n_s;
   assign core_flush = abort || (state == ST_IDLE);
   assign core_arm   = (state == ST_ARM) && sclk_fall;
   assign core_step  = (state == ST_CONV) && sclk_fall && (step_cnt < CNT_W'(WIDTH));
   assign lsb_pos    = step_cnt - CNT_W'(WIDTH);

   sar_seq_core #(.WIDTH(WIDTH)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (core_flush),
      .arm    (core_arm),
      .step   (core_step),
      .cmp_ge (cmp_ge),
      .trial  (trial_code),
      .result (result)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cmd_sr   <= '0;
         cmd_cnt  <= '0;
         step_cnt <= '0;
         dout_q   <= 1'b0;
         busy_q   <= 1'b0;
         single_q <= 1'b0;
         addr_q   <= '0;
      end else if (abort) begin
         state    <= ST_IDLE;
         cmd_cnt  <= '0;
         step_cnt <= '0;
         dout_q   <= 1'b0;
         busy_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (sclk_rise && din_s) begin
                  state   <= ST_CMD;
                  cmd_cnt <= '0;
               end
            end
            ST_CMD: begin
               if (sclk_rise) begin
                  cmd_sr  <= {cmd_sr[CMD_W-2:0], din_s};
                  cmd_cnt <= cmd_cnt + 1'b1;
                  if (cmd_cnt == CC_W'(CMD_W - 1)) begin
                     {single_q, addr_q} <= {cmd_sr[CMD_W-2:0], din_s};
                     state              <= ST_ARM;
                  end
               end
            end
            ST_ARM: begin
               if (sclk_fall) begin
                  state    <= ST_CONV;
                  busy_q   <= 1'b1;
                  step_cnt <= '0;
               end
            end
            ST_CONV: begin
               if (sclk_fall) begin
                  step_cnt <= step_cnt + 1'b1;
                  if (step_cnt < CNT_W'(WIDTH)) begin
                     dout_q <= cmp_ge;
                  end else if (step_cnt < CNT_W'(2 * WIDTH)) begin
                     dout_q <= result[lsb_pos[IDX_W-1:0]];
                  end else begin
                     dout_q <= 1'b0;
                     busy_q <= 1'b0;
                     state  <= ST_DONE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign mux_addr   = addr_q;
   assign mux_single = single_q;
   assign dout_bit   = dout_q;
   assign busy_bit   = busy_q;
   assign dout_oe    = ~cs_n_s;
   assign busy_oe    = ~cs_n_s;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int WIDTH      = 8,
   parameter int SYNC_DEPTH = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             sclk_fall,
   input logic [WIDTH-1:0] trial_code,
   input logic             dout_bit,
   input logic             dout_oe,
   input logic             busy_bit,
   input logic             busy_oe
);
   localparam int HC_W = $clog2(SYNC_DEPTH + 3) + 1;
   localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

   logic [HC_W-1:0] hi_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n || !cs_n) hi_cnt <= '0;
      else if (hi_cnt < HC_W'(SYNC_DEPTH + 2)) hi_cnt <= hi_cnt + 1'b1;
   end

   assert_oe_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe == busy_oe);

   assert_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt > HC_W'(SYNC_DEPTH)) |-> !dout_oe);

   assert_abort_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |=> (trial_code == '0));

   assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_bit) |-> (trial_code == TOP_BIT));

   assert_dout_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && $past(dout_oe) && !$stable(dout_bit)) |-> $past(sclk_fall));

   assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_bit) && dout_oe) |-> $past(sclk_fall));
endmodule

bind sar_seq sar_seq_chk #(.WIDTH(WIDTH), .SYNC_DEPTH(SYNC_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .sclk_fall  (sclk_fall),
   .trial_code (trial_code),
   .dout_bit   (dout_bit),
   .dout_oe    (dout_oe),
   .busy_bit   (busy_bit),
   .busy_oe    (busy_oe)
);

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       cs_n = 1'b1;
   logic       din = 1'b0;
   logic       cmp_ge;
   logic [7:0] trial_code;
   logic [2:0] mux_addr;
   logic       mux_single, dout_bit, dout_oe, busy_bit, busy_oe;

   logic [7:0] analog = 8'h00;
   logic       hi_sample;
   int         n_chk = 0;
   int         n_err = 0;
   bit         finished = 0;

   always #2 clk = ~clk;

   assign cmp_ge = (analog >= trial_code);

   sar_seq dut_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
      .cmp_ge(cmp_ge), .trial_code(trial_code), .mux_addr(mux_addr),
      .mux_single(mux_single), .dout_bit(dout_bit), .dout_oe(dout_oe),
      .busy_bit(busy_bit), .busy_oe(busy_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // one serial period: low half, rise, high half, fall, then settle
   task automatic pulse(input logic d);
      din = d;
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      hi_sample = dout_bit;
      sclk = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_cmd(input logic single, input logic [2:0] addr);
      pulse(1'b1);
      pulse(single);
      pulse(addr[2]);
      pulse(addr[1]);
      pulse(addr[0]);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 dout_oe", dout_oe, 0);
      chk("R1 busy_oe", busy_oe, 0);
      chk("R1 busy", busy_bit, 0);
      chk("R1 trial", trial_code, 0);
   endtask

   task automatic t_hiz;
      cs_n = 1'b1;
      analog = 8'h33;
      for (int i = 0; i < 6; i++) pulse(1'b1);
      chk("R2 dout_oe with select high", dout_oe, 0);
      chk("R2 busy_oe with select high", busy_oe, 0);
      chk("R2 busy with select high", busy_bit, 0);
   endtask

   task automatic t_conv(input logic [7:0] vpos, input logic [7:0] vneg,
                         input logic single, input logic [2:0] addr, input int lead);
      logic [7:0] code;
      logic [7:0] keep;
      logic       last;
      analog = (vpos > vneg) ? vpos - vneg : 8'h00;
      code = analog;
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R2 enables on", {31'd0, dout_oe & busy_oe}, 1);
      for (int i = 0; i < lead; i++) pulse(1'b0);
      if (lead > 0) chk("R3 leading zeros ignored", busy_bit, 0);
      send_cmd(single, addr);
      chk("R4 busy rises", busy_bit, 1);
      chk("R4 first trial", trial_code, 8'h80);
      chk("R3 address", mux_addr, addr);
      chk("R3 mode", mux_single, single);
      last = dout_bit;
      for (int k = 0; k < 8; k++) begin
         pulse(1'b0);
         chk("R11 no change at rise", hi_sample, last);
         chk((code == 0) ? "R9 msb-first bit" : "R6 msb-first bit", dout_bit, code[7-k]);
         keep = code & (8'hFF << (7 - k));
         chk("R5 trial", trial_code, (k < 7) ? (keep | (8'h01 << (6 - k))) : code);
         last = dout_bit;
      end
      for (int k = 0; k < 8; k++) begin
         pulse(1'b0);
         chk("R11 no change at rise", hi_sample, last);
         chk((code == 0) ? "R9 lsb-first bit" : "R7 lsb-first bit", dout_bit, code[k]);
         chk("R7 busy held", busy_bit, 1);
         last = dout_bit;
      end
      pulse(1'b0);
      chk("R8 busy ends", busy_bit, 0);
      chk("R8 dout low", dout_bit, 0);
      pulse(1'b1);
      pulse(1'b1);
      chk("R8 no restart without select", busy_bit, 0);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R2 enables off", {31'd0, dout_oe | busy_oe}, 0);
   endtask

   task automatic t_abort;
      analog = 8'hC3;
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      send_cmd(1'b0, 3'd4);
      for (int k = 0; k < 3; k++) pulse(1'b0);
      chk("R10 busy before abort", busy_bit, 1);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R10 busy after abort", busy_bit, 0);
      chk("R10 trial after abort", trial_code, 0);
      chk("R10 enable after abort", dout_oe, 0);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      for (int k = 0; k < 6; k++) pulse(1'b0);
      chk("R10 no conversion without start", busy_bit, 0);
      chk("R10 trial idle", trial_code, 0);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_hiz();
      t_conv(8'hA5, 8'h00, 1'b1, 3'd5, 0);
      t_conv(8'hFF, 8'h00, 1'b0, 3'd2, 2);
      t_conv(8'h40, 8'h90, 1'b1, 3'd7, 0);
      t_conv(8'h55, 8'h55, 1'b0, 3'd0, 1);
      t_conv(8'h01, 8'h00, 1'b1, 3'd3, 0);
      t_abort();
      t_conv(8'h9E, 8'h10, 1'b0, 3'd6, 0);
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule